// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block holds a small set of recent virtual-page to physical-frame translations. Any translation may sit in any entry. Every entry also carries the identifier of the process that owns it. Translations from several processes can therefore stay resident together, and a context switch needs no flush. A lookup compares the requested page number and process identifier against every entry at once. One cycle later the block reports one of three outcomes: a usable hit with the frame number and permission bits, a miss, or a protection fault.

A miss is only reported. The block does not resolve it. An external handler walks the page tables and loads the missing translation through the fill port. Until then, the dependent memory access must not proceed. The fill port and both invalidate ports act only while the privileged-mode input is high. Unprivileged code therefore cannot change the buffer's contents. A victim for a new translation is chosen by a round-robin pointer.

Top module: `pid_tlb`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` is low, and any lookup reports a miss.
- R2: A lookup presented with `lk_valid` high at one clock edge yields, at the next edge, `rsp_valid` high with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high. The lookup uses the contents as they were before any fill or invalidate accepted at that same edge.
- R3: A lookup matches an entry only when the entry is valid and both its page number and its process identifier equal the request. On a hit, `rsp_ppn` carries the stored frame number.
- R4: When no entry matches, `rsp_miss` is raised, `rsp_ppn` and `rsp_perm` are zero, and no entry is created or changed.
- R5: Permission bit 0 means writable and bit 1 means accessible from user mode. A matching lookup faults when it is a store (`lk_store`=1) to an entry with bit 0 clear, or a user-mode access (`lk_user`=1) to an entry with bit 1 clear. A fault reports the entry's bits on `rsp_perm` and drives `rsp_ppn` to zero.
- R6: An accepted fill is written into the entry selected by a round-robin pointer. The pointer is 0 after reset and advances by one, modulo ENTRIES, on every accepted fill. The (ENTRIES+1)-th distinct fill after reset therefore evicts the first.
- R7: A fill whose page number and process identifier match a valid entry overwrites that entry. No duplicate is created, so later lookups return the new frame number.
- R8: A privileged `inv_all` invalidates every entry.
- R9: A privileged `inv_pid_en` invalidates every entry whose process identifier equals `inv_pid` and leaves all other entries intact.
- R10: While `priv_mode` is low, `fill_en`, `inv_all` and `inv_pid_en` have no effect.
- R11: A fill requested in the same cycle as an accepted invalidate is dropped, and the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 1 | High when the requester runs privileged; gates fill and invalidate |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_pid | input | PID_W | Current process identifier |
| lk_store | input | 1 | Lookup is for a store |
| lk_user | input | 1 | Lookup is made in user mode |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Translation found and access permitted |
| rsp_miss | output | 1 | No translation; the handler must fill |
| rsp_fault | output | 1 | Translation found but access not permitted |
| rsp_ppn | output | PPN_W | Physical frame number on a hit, else zero |
| rsp_perm | output | 2 | Entry permission bits on a hit or fault, else zero |
| fill_en | input | 1 | Load a translation |
| fill_vpn | input | VPN_W | Page number of the loaded translation |
| fill_pid | input | PID_W | Owner process of the loaded translation |
| fill_ppn | input | PPN_W | Frame number of the loaded translation |
| fill_perm | input | 2 | Permission bits of the loaded translation |
| inv_all | input | 1 | Invalidate every entry |
| inv_pid_en | input | 1 | Invalidate entries of one process |
| inv_pid | input | PID_W | Process whose entries are invalidated |

## Verification
The bench looks up the same page under a different process identifier. A design that ignored the process tag would return a false hit there. It refills a resident translation with a new frame number whose bits do not overlap the old one. If a duplicate were allocated, the two frame numbers would be ORed together or the stale one returned. It performs seventeen distinct fills to confirm that the oldest translation, and only that one, is evicted. It also presents a fill together with an invalidate, and a fill together with a lookup of the same page. A design with the wrong priority or timing would keep the dropped fill or report a hit one cycle too early. Finally, fills and invalidates issued with `priv_mode` low are followed by lookups, which would expose any change made by unprivileged code.

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_mode,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_store,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [1:0]       rsp_perm,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_perm,
  input  logic             inv_all,
  input  logic             inv_pid_en,
  input  logic [PID_W-1:0] inv_pid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PID_W-1:0]   e_pid  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [1:0]         e_perm [ENTRIES];
  logic [IDX_W-1:0]   ptr;

  logic [ENTRIES-1:0] lk_match, fl_match, iv_match, wr_sel;
  logic [PPN_W-1:0]   sel_ppn;
  logic [1:0]         sel_perm;

  wire inv_any = priv_mode && (inv_all || inv_pid_en);
  wire do_fill = priv_mode && fill_en && !inv_all && !inv_pid_en;
  wire refill  = |fl_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign lk_match[g] = vld[g] && (e_vpn[g] == lk_vpn) && (e_pid[g] == lk_pid);
    assign fl_match[g] = vld[g] && (e_vpn[g] == fill_vpn) && (e_pid[g] == fill_pid);
    assign iv_match[g] = vld[g] && (e_pid[g] == inv_pid);
    assign wr_sel[g]   = refill ? fl_match[g] : (ptr == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (do_fill && wr_sel[g]) begin
        e_vpn[g]  <= fill_vpn;
        e_pid[g]  <= fill_pid;
        e_ppn[g]  <= fill_ppn;
        e_perm[g] <= fill_perm;
      end
    end
  end

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        sel_ppn  = sel_ppn | e_ppn[i];
        sel_perm = sel_perm | e_perm[i];
      end
    end
  end

  wire hit_any = |lk_match;
  wire viol    = (lk_store && !sel_perm[0]) || (lk_user && !sel_perm[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (inv_any) begin
      vld <= inv_all ? '0 : (vld & ~iv_match);
    end else if (do_fill) begin
      vld <= vld | wr_sel;
      ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_any && !viol;
      rsp_fault <= lk_valid && hit_any && viol;
      rsp_miss  <= lk_valid && !hit_any;
      rsp_ppn   <= (lk_valid && hit_any && !viol) ? sel_ppn : '0;
      rsp_perm  <= (lk_valid && hit_any) ? sel_perm : '0;
    end
  end
endmodule

module pid_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               priv_mode,
  input logic               lk_valid,
  input logic               inv_all,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic [PPN_W-1:0]   rsp_ppn,
  input logic [1:0]         rsp_perm,
  input logic [ENTRIES-1:0] vld,
  input logic [ENTRIES-1:0] lk_match
);
  AST_RSP_TRACK: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1); // R2
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) rsp_miss |-> (rsp_ppn == '0 && rsp_perm == '0)); // R4
  AST_FAULT_NO_PPN: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> rsp_ppn == '0); // R5
  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_match)); // R7
  AST_INV_ALL: assert property (@(posedge clk) disable iff (!rst_n) (priv_mode && inv_all) |=> vld == '0); // R8
  AST_USER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) !priv_mode |=> $stable(vld)); // R10
endmodule

bind pid_tlb pid_tlb_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .lk_valid(lk_valid),
  .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
  .rsp_perm(rsp_perm), .vld(vld), .lk_match(lk_match)
);

// File: tb/pid_tlb_test.sv
module pid_tlb_test;
  localparam int VPN_W = 20, PPN_W = 18, PID_W = 8;

  logic clk = 0, rst_n = 0, priv_mode = 0;
  logic lk_valid = 0, lk_store = 0, lk_user = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PID_W-1:0] lk_pid = '0, fill_pid = '0, inv_pid = '0;
  logic [PPN_W-1:0] fill_ppn = '0, rsp_ppn;
  logic [1:0] fill_perm = '0, rsp_perm;
  logic fill_en = 0, inv_all = 0, inv_pid_en = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  int checks = 0, errors = 0;

  pid_tlb uut (.*);

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired (all requirements unverified)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PID_W-1:0] p, logic [PPN_W-1:0] f,
                      logic [1:0] pm, logic pr);
    @(negedge clk);
    priv_mode = pr; fill_en = 1; fill_vpn = v; fill_pid = p; fill_ppn = f; fill_perm = pm;
    @(negedge clk);
    fill_en = 0; priv_mode = 0;
  endtask

  // result packed as {valid,hit,miss,fault,perm,ppn}
  task automatic look(string req, logic [VPN_W-1:0] v, logic [PID_W-1:0] p, logic st, logic us,
                      logic h, logic m, logic f, logic [1:0] pm, logic [PPN_W-1:0] ppn);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; lk_pid = p; lk_store = st; lk_user = us;
    @(negedge clk);
    lk_valid = 0; lk_store = 0; lk_user = 0;
    chk(req, {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_perm, rsp_ppn},
             {1'b1, h, m, f, pm, ppn});
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    look("R1 empty lookup misses", 20'h0, 8'h0, 0, 0, 0, 1, 0, 2'b00, 0);
    @(negedge clk);
    chk("R2 rsp_valid drops when idle", rsp_valid, 0);
  endtask

  task automatic t_basic();
    fill(20'h12345, 8'd3, 18'h00ABC, 2'b11, 1);
    look("R3 hit returns frame", 20'h12345, 8'd3, 0, 1, 1, 0, 0, 2'b11, 18'h00ABC);
    look("R3 other pid misses", 20'h12345, 8'd4, 0, 0, 0, 1, 0, 2'b00, 0);
    look("R4 other page misses", 20'h12346, 8'd3, 0, 0, 0, 1, 0, 2'b00, 0);
    look("R4 miss created nothing", 20'h12346, 8'd3, 0, 0, 0, 1, 0, 2'b00, 0);
  endtask

  task automatic t_perm();
    fill(20'h00200, 8'd3, 18'h00055, 2'b10, 1);
    look("R5 user store to read-only faults", 20'h00200, 8'd3, 1, 1, 0, 0, 1, 2'b10, 0);
    look("R5 user load to read-only hits", 20'h00200, 8'd3, 0, 1, 1, 0, 0, 2'b10, 18'h00055);
    fill(20'h00300, 8'd3, 18'h00077, 2'b01, 1);
    look("R5 user load to kernel page faults", 20'h00300, 8'd3, 0, 1, 0, 0, 1, 2'b01, 0);
    look("R5 kernel store to kernel page hits", 20'h00300, 8'd3, 1, 0, 1, 0, 0, 2'b01, 18'h00077);
  endtask

  task automatic t_overwrite();
    fill(20'h00400, 8'd5, 18'h0000F, 2'b11, 1);
    fill(20'h00400, 8'd5, 18'h000F0, 2'b11, 1);
    look("R7 refill replaces frame", 20'h00400, 8'd5, 0, 0, 1, 0, 0, 2'b11, 18'h000F0);
  endtask

  task automatic t_nopriv();
    fill(20'h00500, 8'd3, 18'h00011, 2'b11, 0);
    look("R10 unprivileged fill ignored", 20'h00500, 8'd3, 0, 0, 0, 1, 0, 2'b00, 0);
    @(negedge clk);
    priv_mode = 0; inv_all = 1; inv_pid_en = 1; inv_pid = 8'd3;
    @(negedge clk);
    inv_all = 0; inv_pid_en = 0;
    look("R10 unprivileged invalidate ignored", 20'h12345, 8'd3, 0, 0, 1, 0, 0, 2'b11, 18'h00ABC);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    priv_mode = 1; fill_en = 1; fill_vpn = 20'h00800; fill_pid = 8'd9; fill_ppn = 18'h00123;
    fill_perm = 2'b11;
    lk_valid = 1; lk_vpn = 20'h00800; lk_pid = 8'd9;
    @(negedge clk);
    fill_en = 0; priv_mode = 0; lk_valid = 0;
    chk("R2 lookup sees state before same-edge fill", {rsp_valid, rsp_miss}, 2'b11);
    look("R2 fill visible afterwards", 20'h00800, 8'd9, 0, 0, 1, 0, 0, 2'b11, 18'h00123);
  endtask

  task automatic t_inv_pid();
    fill(20'h00600, 8'd7, 18'h00600, 2'b11, 1);
    fill(20'h00600, 8'd8, 18'h00601, 2'b11, 1);
    @(negedge clk);
    priv_mode = 1; inv_pid_en = 1; inv_pid = 8'd7;
    @(negedge clk);
    priv_mode = 0; inv_pid_en = 0;
    look("R9 invalidated pid misses", 20'h00600, 8'd7, 0, 0, 0, 1, 0, 2'b00, 0);
    look("R9 other pid kept", 20'h00600, 8'd8, 0, 0, 1, 0, 0, 2'b11, 18'h00601);
  endtask

  task automatic t_conflict();
    @(negedge clk);
    priv_mode = 1; inv_pid_en = 1; inv_pid = 8'd99;
    fill_en = 1; fill_vpn = 20'h00700; fill_pid = 8'd1; fill_ppn = 18'h00700; fill_perm = 2'b11;
    @(negedge clk);
    priv_mode = 0; inv_pid_en = 0; fill_en = 0;
    look("R11 fill dropped under invalidate", 20'h00700, 8'd1, 0, 0, 0, 1, 0, 2'b00, 0);
  endtask

  task automatic t_inv_all();
    @(negedge clk);
    priv_mode = 1; inv_all = 1;
    @(negedge clk);
    priv_mode = 0; inv_all = 0;
    look("R8 invalidate-all clears pid 3", 20'h12345, 8'd3, 0, 0, 0, 1, 0, 2'b00, 0);
    look("R8 invalidate-all clears pid 8", 20'h00600, 8'd8, 0, 0, 0, 1, 0, 2'b00, 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 17; i++)
      fill(20'h01000 + 20'(i), 8'd1, 18'(i + 1), 2'b11, 1);
    look("R6 oldest evicted", 20'h01000, 8'd1, 0, 0, 0, 1, 0, 2'b00, 0);
    look("R6 second oldest kept", 20'h01001, 8'd1, 0, 0, 1, 0, 0, 2'b11, 18'd2);
    look("R6 newest present", 20'h01010, 8'd1, 0, 0, 1, 0, 0, 2'b11, 18'd17);
    fill(20'h02000, 8'd1, 18'h3FFFF, 2'b11, 1);
    look("R6 next fill evicts next slot", 20'h01001, 8'd1, 0, 0, 0, 1, 0, 2'b00, 0);
    look("R6 third oldest kept", 20'h01002, 8'd1, 0, 0, 1, 0, 0, 2'b11, 18'd3);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_perm();
    t_overwrite();
    t_nopriv();
    t_same_cycle();
    t_inv_pid();
    t_conflict();
    t_inv_all();
    t_round_robin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule